// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

This block takes a stereo PCM stream carried on three wires (a bit clock, a word clock and a serial data line) and turns it into parallel left/right sample pairs. Each word-clock period carries one left and one right word. The words arrive most significant bit first in two's complement. A 3-bit format code selects the framing. The framing may be right-justified with 16, 20 or 24 bits, left-justified with 24 bits, or I2S with 16 or 24 bits. Two codes are reserved.

Deserialization runs on the bit clock. Each finished pair is passed to the system clock domain through a toggle-and-synchronizer handoff. It appears there as two 24-bit words, left-aligned so that full scale is the same in every format, together with a one-cycle valid strobe. A status output flags a reserved format code.

Top module: `aud_serial_rx`

## Requirements
- R1: Serial data is sampled on the rising edge of `bclk` and is taken as most significant bit first in two's complement. The sign bit of the word lands in bit 23 of the output.
- R2: Codes 000, 001 and 010 select right-justified framing with 16, 20 and 24-bit words. The least significant bit is the last bit sampled before a word-clock transition.
- R3: Code 011 selects left-justified 24-bit framing. The most significant bit is the first bit sampled after a word-clock transition.
- R4: Codes 100 and 101 select I2S framing with 16 and 24-bit words. The most significant bit is the second bit sampled after a word-clock transition.
- R5: In right- and left-justified framing, `wclk` high marks the left half-frame. In I2S framing, `wclk` low marks the left half-frame.
- R6: A word shorter than 24 bits is placed in the upper bits of its output, and the bits below it are zero.
- R7: Codes 110 and 111 deliver pairs whose samples are zero, and `fmt_err` is then 1. For every other code `fmt_err` is 0.
- R8: Each left/right pair is announced by `out_valid` high for exactly one `sys_clk` cycle. The announcement follows the word-clock transition that ends the right half-frame. `out_left` and `out_right` hold their values between announcements.
- R9: Bits in a half-frame beyond the selected word are ignored. Half-frames may differ in length by up to ±2 bits from a 32-bit half.
- R10: After reset, `out_valid`, `out_left` and `out_right` are 0. The half-frame that is cut short by reset is discarded. The first pair comes from the first complete left and right half-frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; output side |
| sys_rst | input | 1 | Synchronous active-high reset, system domain (also synchronized into the bit-clock domain) |
| bclk | input | 1 | Serial bit clock |
| wclk | input | 1 | Word clock, one period per stereo sample |
| sdata | input | 1 | Serial audio data |
| fmt | input | 3 | Framing code (quasi-static) |
| out_left | output | 24 | Left sample, left-aligned two's complement |
| out_right | output | 24 | Right sample, left-aligned two's complement |
| out_valid | output | 1 | One-cycle strobe for a new pair |
| fmt_err | output | 1 | Reserved framing code selected |

## Verification
The bench builds the block with its defaults: a 6-bit saturating bit counter and two synchronizer stages. The bit clock runs at one fifth of the system clock, so every handoff latency through the two-stage synchronizer shows up within a single half-frame. A 6-bit counter covers half-frames of up to 63 bits. That lets the bench stretch and shrink half-frames around 32 bits and also drive half-frames exactly as long as the word. The ignored surplus bits and the minimal-length corner are therefore both exercised for every framing code, including the reserved ones.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int LEN_W    = 5;

    typedef enum logic [2:0] {
        FMT_RJ16  = 3'b000,
        FMT_RJ20  = 3'b001,
        FMT_RJ24  = 3'b010,
        FMT_LJ24  = 3'b011,
        FMT_I2S16 = 3'b100,
        FMT_I2S24 = 3'b101,
        FMT_RSV6  = 3'b110,
        FMT_RSV7  = 3'b111
    } fmt_code_e;

    typedef struct packed {
        logic             reserved;
        logic             right_aligned;
        logic             low_is_left;   // also means MSB delayed by one bit
        logic [LEN_W-1:0] word_len;
    } framing_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } stereo_t;

    function automatic framing_t decode_fmt(input logic [2:0] code);
        framing_t f;
        f = '{reserved: 1'b0, right_aligned: 1'b0, low_is_left: 1'b0, word_len: LEN_W'(24)};
        case (fmt_code_e'(code))
            FMT_RJ16:  begin f.right_aligned = 1'b1; f.word_len = LEN_W'(16); end
            FMT_RJ20:  begin f.right_aligned = 1'b1; f.word_len = LEN_W'(20); end
            FMT_RJ24:  begin f.right_aligned = 1'b1; end
            FMT_LJ24:  ;
            FMT_I2S16: begin f.low_is_left = 1'b1; f.word_len = LEN_W'(16); end
            FMT_I2S24: begin f.low_is_left = 1'b1; end
            default:   begin f.reserved = 1'b1; f.word_len = '0; end
        endcase
        return f;
    endfunction

    function automatic logic [SAMPLE_W-1:0] left_align(input logic [SAMPLE_W-1:0] raw,
                                                       input logic [LEN_W-1:0] len);
        logic [SAMPLE_W-1:0] r;
        case (len)
            LEN_W'(16): r = {raw[15:0], 8'h00};
            LEN_W'(20): r = {raw[19:0], 4'h0};
            LEN_W'(24): r = raw;
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aud_rx_rst_sync.sv
module aud_rx_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], rst_in};
    end

    assign rst_out = chain[STAGES-1] | rst_in;
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic    bclk,
    input  logic    rst,
    input  logic    wclk,
    input  logic    sdata,
    input  logic [2:0] fmt,
    output stereo_t pair_q,
    output logic    pair_tgl,
    output logic    wclk_prev
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    framing_t            cfg;
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    idx;
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] left_hold;
    logic [SAMPLE_W-1:0] word;
    logic                primed, have_left;
    logic                edge_w, in_win, done_left;
    int                  first_bit;

    assign cfg       = decode_fmt(fmt);
    assign edge_w    = wclk ^ wclk_prev;
    assign idx       = edge_w ? '0 : cnt;
    assign first_bit = cfg.low_is_left ? 1 : 0;
    assign in_win    = cfg.right_aligned ||
                       ((int'(idx) >= first_bit) && (int'(idx) < first_bit + int'(cfg.word_len)));
    assign word      = cfg.reserved ? '0 : left_align(shreg, cfg.word_len);
    assign done_left = cfg.low_is_left ? ~wclk_prev : wclk_prev;

    always_ff @(posedge bclk) begin
        if (rst) begin
            wclk_prev <= wclk;
            cnt       <= '0;
            shreg     <= '0;
            primed    <= 1'b0;
            have_left <= 1'b0;
            left_hold <= '0;
            pair_q    <= '0;
            pair_tgl  <= 1'b0;
        end else begin
            wclk_prev <= wclk;
            if (in_win) shreg <= {shreg[SAMPLE_W-2:0], sdata};
            if (edge_w) begin
                cnt    <= CNT_W'(1);
                primed <= 1'b1;
                if (primed) begin
                    if (done_left) begin
                        left_hold <= word;
                        have_left <= 1'b1;
                    end else if (have_left) begin
                        pair_q    <= '{left: left_hold, right: word};
                        pair_tgl  <= ~pair_tgl;
                        have_left <= 1'b0;
                    end
                end
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/aud_rx_pair_cdc.sv
module aud_rx_pair_cdc
    import aud_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  stereo_t pair_in,
    input  logic    tgl_in,
    output stereo_t pair_out,
    output logic    valid
);
    logic [STAGES:0] sync;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) sync[g] <= 1'b0;
                else     sync[g] <= (g == 0) ? tgl_in : sync[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_out <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= sync[STAGES] ^ sync[STAGES-1];
            if (sync[STAGES] ^ sync[STAGES-1]) pair_out <= pair_in;
        end
    end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic        sys_clk,
    input  logic        sys_rst,
    input  logic        bclk,
    input  logic        wclk,
    input  logic        sdata,
    input  logic [2:0]  fmt,
    output logic [23:0] out_left,
    output logic [23:0] out_right,
    output logic        out_valid,
    output logic        fmt_err
);
    logic    rst_b;
    logic    pair_tgl;
    logic    wclk_prev;
    stereo_t pair_b;
    stereo_t pair_s;
    framing_t cfg_s;

    aud_rx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk(bclk), .rst_in(sys_rst), .rst_out(rst_b)
    );

    aud_rx_deser #(.CNT_W(CNT_W)) u_deser (
        .bclk(bclk), .rst(rst_b), .wclk(wclk), .sdata(sdata), .fmt(fmt),
        .pair_q(pair_b), .pair_tgl(pair_tgl), .wclk_prev(wclk_prev)
    );

    aud_rx_pair_cdc #(.STAGES(SYNC_STAGES)) u_cdc (
        .clk(sys_clk), .rst(sys_rst), .pair_in(pair_b), .tgl_in(pair_tgl),
        .pair_out(pair_s), .valid(out_valid)
    );

    assign cfg_s     = decode_fmt(fmt);
    assign out_left  = pair_s.left;
    assign out_right = pair_s.right;

    always_ff @(posedge sys_clk) begin
        if (sys_rst) fmt_err <= 1'b0;
        else         fmt_err <= cfg_s.reserved;
    end
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk (
    input logic        sys_clk,
    input logic        sys_rst,
    input logic        bclk,
    input logic        rst_b,
    input logic        wclk,
    input logic        wclk_prev,
    input logic        pair_tgl,
    input logic [2:0]  fmt,
    input logic [23:0] out_left,
    input logic [23:0] out_right,
    input logic        out_valid,
    input logic        fmt_err
);
    logic seen_clk;
    always_ff @(posedge sys_clk) seen_clk <= ~sys_rst;

    assert_valid_single_R8: assert property (@(posedge sys_clk) disable iff (sys_rst)
        out_valid |=> !out_valid);

    assert_hold_R8: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (seen_clk && !out_valid) |-> ($stable(out_left) && $stable(out_right)));

    assert_reserved_zero_R7: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (out_valid && fmt_err) |-> (out_left == 24'd0 && out_right == 24'd0));

    assert_align16_R6: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (out_valid && (fmt == 3'b000 || fmt == 3'b100)) |-> (out_left[7:0] == 8'd0 && out_right[7:0] == 8'd0));

    assert_align20_R6: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (out_valid && fmt == 3'b001) |-> (out_left[3:0] == 4'd0 && out_right[3:0] == 4'd0));

    assert_pair_on_edge_R8: assert property (@(posedge bclk) disable iff (rst_b)
        (pair_tgl != $past(pair_tgl)) |-> ($past(wclk) != $past(wclk_prev)));
endmodule

bind aud_serial_rx aud_serial_rx_chk u_chk (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .bclk(bclk), .rst_b(rst_b),
    .wclk(wclk), .wclk_prev(wclk_prev), .pair_tgl(pair_tgl), .fmt(fmt),
    .out_left(out_left), .out_right(out_right), .out_valid(out_valid), .fmt_err(fmt_err)
);

// File: tb/tb_aud_serial_rx.sv
module tb_aud_serial_rx;
    logic        sys_clk = 1'b0;
    logic        sys_rst = 1'b1;
    logic        bclk    = 1'b0;
    logic        wclk    = 1'b0;
    logic        sdata   = 1'b0;
    logic [2:0]  fmt     = 3'b000;
    logic [23:0] out_left, out_right;
    logic        out_valid, fmt_err;

    int n_checks = 0;
    int n_fail   = 0;
    int n_exp    = 0;
    int n_got    = 0;
    logic [23:0] exp_l [0:127];
    logic [23:0] exp_r [0:127];
    bit done = 1'b0;

    aud_serial_rx dut (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .bclk(bclk), .wclk(wclk), .sdata(sdata),
        .fmt(fmt), .out_left(out_left), .out_right(out_right), .out_valid(out_valid),
        .fmt_err(fmt_err)
    );

    always #4  sys_clk = ~sys_clk;   // 125 MHz
    always #20 bclk    = ~bclk;

    function automatic int f_len(input logic [2:0] f);
        case (f)
            3'b000, 3'b100: return 16;
            3'b001:         return 20;
            3'b010, 3'b011, 3'b101: return 24;
            default:        return 0;
        endcase
    endfunction
    function automatic bit f_i2s(input logic [2:0] f); return f == 3'b100 || f == 3'b101; endfunction
    function automatic bit f_rj(input logic [2:0] f);  return f <= 3'b010; endfunction

    function automatic logic [23:0] f_expect(input logic [2:0] f, input logic [23:0] s);
        int n;
        n = f_len(f);
        if (n == 0) return 24'd0;
        return (s & ((24'd1 << n) - 24'd1)) << (24 - n);
    endfunction

    function automatic logic f_bit(input logic [2:0] f, input logic [23:0] s, input int idx,
                                   input int h, input logic junk);
        int n;
        n = f_len(f);
        if (n == 0) return junk;
        if (f_rj(f))  return (idx >= h - n) ? s[h - 1 - idx] : junk;   // R2
        if (f_i2s(f)) return (idx >= 1 && idx <= n) ? s[n - idx] : junk; // R4
        return (idx < n) ? s[n - 1 - idx] : junk;                        // R3
    endfunction

    task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_half(input logic lvl, input logic [2:0] f, input logic [23:0] s, input int h);
        for (int i = 0; i < h; i++) begin
            @(negedge bclk);
            wclk  = lvl;
            sdata = f_bit(f, s, i, h, 1'($urandom));   // R9: surplus bits random
        end
    endtask

    // pair monitor (R8, R5, R1)
    always @(negedge sys_clk) begin
        if (!sys_rst && out_valid) begin
            if (n_got < n_exp)
                check(out_left == exp_l[n_got] && out_right == exp_r[n_got], "R8/R5 pair",
                      {out_left, out_right}, {exp_l[n_got], exp_r[n_got]});
            else
                check(1'b0, "R8 unexpected pair", {out_left, out_right}, 48'd0);
            n_got++;
        end
    end

    task automatic run_block(input logic [2:0] f, input int nfr);
        logic lvl_l;
        logic [23:0] l, r;
        int hl, hr, d;
        lvl_l = f_i2s(f) ? 1'b0 : 1'b1;   // R5
        fmt   = f;
        sys_rst = 1'b1;
        wclk  = ~lvl_l;
        repeat (40) @(posedge sys_clk);
        sys_rst = 1'b0;
        @(negedge sys_clk);
        check(out_valid == 1'b0 && out_left == 24'd0 && out_right == 24'd0, "R10 reset state",
              {out_left, out_right}, 48'd0);
        @(negedge sys_clk);
        check(fmt_err == (f_len(f) == 0), "R7 fmt_err", 48'(fmt_err), 48'(f_len(f) == 0));
        send_half(~lvl_l, f, 24'd0, 6);   // partial half, discarded (R10)
        for (int k = 0; k < nfr; k++) begin
            l = 24'($urandom); r = 24'($urandom);
            d = int'($urandom % 5) - 2;
            hl = 32 + d; hr = 32 - d;          // R9 duty deviation
            if (k == 0 && f == 3'b010) begin l = 24'h800000; r = 24'h7FFFFF; end   // R1 extremes
            if (k == 0 && f == 3'b000) begin l = 24'h008000; r = 24'h000001; end   // R1/R6
            if (k == 1) begin                   // minimal half length
                hl = f_len(f) + (f_i2s(f) ? 1 : 0);
                if (hl < 4) hl = 4;
                hr = 64 - hl;
            end
            exp_l[n_exp] = f_expect(f, l);
            exp_r[n_exp] = f_expect(f, r);
            n_exp++;
            send_half(lvl_l, f, l, hl);
            send_half(~lvl_l, f, r, hr);
        end
        send_half(lvl_l, f, 24'd0, 3);
        repeat (30) @(posedge sys_clk);
        check(n_got == n_exp, "R8 pair count", 48'(n_got), 48'(n_exp));
        n_got = n_exp;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_block(3'b000, 8);   // R2 16
        run_block(3'b001, 8);   // R2 20, R6
        run_block(3'b010, 8);   // R2 24
        run_block(3'b011, 8);   // R3
        run_block(3'b100, 8);   // R4 16
        run_block(3'b101, 8);   // R4 24
        run_block(3'b110, 4);   // R7
        run_block(3'b111, 4);   // R7
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge sys_clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule